// File: doc/BRIEF.md
# Two-Wire Bus Slave with Status Flags

This block is a slave on a two-wire serial bus. It waits for a START, takes in a 7-bit address and a direction bit, and acknowledges only its own address, which is set by a parameter. A write from the master makes it a receiver: it acknowledges every data byte and keeps the byte for software. A read from the master makes it a transmitter: it shifts out the contents of a one-byte holding register, most significant bit first. The master acknowledges each byte on the ninth clock pulse. When the master does not acknowledge, the slave stops driving the data line.

Software or a DMA channel drives the block through a small synchronous register port. It can load the transmit holding register, read the last received byte, read and clear the status flags, set an interrupt mask, and load a byte counter. The counter is loaded with the number of bytes expected, so the final byte of a message, such as an SMBus packet error code, can be recognised. It also counts down as bytes move. The transmit-ready flag acts as the request line for a DMA transmit channel. Both bus lines are open drain: the block only ever pulls a line low, through an output enable, and it samples both lines through a two-flop synchronizer.

Top module: `i2c_flag_slave`

## Requirements
- R1: After reset, STATUS (address 2) reads 0x10 (only transmit-ready set), IRQ_EN (address 3) and COUNT (address 4) read 0, irq is low and neither line is pulled low.
- R2: When an address byte after START carries the own address with R/W = 0, the slave pulls SDA low on the ninth pulse and clears the direction bit (STATUS bit 0).
- R3: An address byte that carries a different address is not acknowledged. The data bytes that follow are not acknowledged either, no status flag changes, and the STOP that ends it does not set transfer-complete.
- R4: In receive mode each data byte is acknowledged, is readable at RX_DATA (address 1) and sets byte-done (STATUS bit 1).
- R5: COUNT decreases by one for each acknowledged data byte in either direction and stays at zero once it reaches zero. A write to address 4 loads it.
- R6: When an address byte carries the own address with R/W = 1, the slave sets the direction bit and sends the holding register (address 0), most significant bit first. The slave changes SDA only while SCL is low.
- R7: Transmit-ready (STATUS bit 4) is 1 while the holding register is empty: after reset, and once its byte has moved into the shifter. A write to address 0 clears it.
- R8: If the master does not acknowledge a transmitted byte, the slave sets the no-acknowledge flag (STATUS bit 2) and leaves SDA released until the next START, so any further bits read back as 1.
- R9: A START that arrives while the slave is addressed sets the repeated-START flag (STATUS bit 3). A START from an idle bus does not set it.
- R10: A STOP that ends a transfer to this slave sets transfer-complete (STATUS bit 5).
- R11: Writing 1 to bits 1, 2, 3 or 5 of STATUS clears those flags. Writing 0 leaves a flag as it is, and writes never change bits 0 and 4.
- R12: irq is high exactly when some STATUS bit and the same IRQ_EN bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| scl_oe | output | 1 | Pull clock line low (never asserted) |
| sda_oe | output | 1 | Pull data line low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a master no-acknowledge partway through a multi-byte read. After it, the slave must keep SDA released while the master goes on clocking, and only the later STOP may complete the transfer. The bench models an open-drain master that reads the first byte with an acknowledge and the second without one. It then clocks a whole extra byte and checks that this byte reads 0xFF. Before the STOP it checks that COUNT did not change for the byte the master refused. A repeated START and a foreign address are also driven, with STOP placed after each so that the completion flag can be told apart.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
    localparam int STAT_W  = 6;
    localparam int B_TRA   = 0;
    localparam int B_BTF   = 1;
    localparam int B_NAK   = 2;
    localparam int B_REP   = 3;
    localparam int B_TXRDY = 4;
    localparam int B_TCOMP = 5;

    localparam logic [2:0] RA_THR  = 3'd0;
    localparam logic [2:0] RA_RXD  = 3'd1;
    localparam logic [2:0] RA_STAT = 3'd2;
    localparam logic [2:0] RA_IEN  = 3'd3;
    localparam logic [2:0] RA_CNT  = 3'd4;

    localparam logic [STAT_W-1:0] CLR_MASK =
        STAT_W'((1 << B_BTF) | (1 << B_NAK) | (1 << B_REP) | (1 << B_TCOMP));

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_AACK, PH_RX, PH_RACK, PH_TX, PH_TACK, PH_WAIT
    } phase_t;
endpackage

// File: rtl/i2c_flag_sync.sv
module i2c_flag_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe_d, pipe_q;
        if (STAGES > 1) begin : g_deep
            assign pipe_d = {pipe_q[STAGES-2:0], din[g]};
        end else begin : g_one
            assign pipe_d = din[g];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= pipe_d;
        end
        assign dout[g] = pipe_q[STAGES-1];
    end
endmodule

// File: rtl/i2c_flag_cond.sv
module i2c_flag_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    assign scl_rise  = scl_s && !prev_q.scl;
    assign scl_fall  = !scl_s && prev_q.scl;
    assign start_det = scl_s && prev_q.scl && prev_q.sda && !sda_s;
    assign stop_det  = scl_s && prev_q.scl && !prev_q.sda && sda_s;
endmodule

// File: rtl/i2c_flag_slave.sv
module i2c_flag_slave
    import i2c_flag_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR    = 7'h2A,
    parameter int         CNT_W       = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W + 1);
    localparam logic [BIT_W-1:0] BITS_FULL = BIT_W'(BYTE_W);
    localparam logic [BIT_W-1:0] BITS_LAST = BIT_W'(BYTE_W - 1);

    typedef struct packed {
        phase_t              phase;
        logic [BIT_W-1:0]    bits;
        logic [BYTE_W-1:0]   shreg;
        logic [BYTE_W-1:0]   thr;
        logic [BYTE_W-1:0]   rxd;
        logic [STAT_W-1:0]   stat;
        logic [STAT_W-1:0]   ien;
        logic [CNT_W-1:0]    nbytes;
        logic                drive;
        logic                active;
    } core_t;

    core_t d, q;
    logic [1:0] lines_s;
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [STAT_W-1:0] w1c;

    i2c_flag_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    i2c_flag_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    always_comb begin
        d   = q;
        w1c = '0;
        if (reg_wr) begin
            case (reg_addr)
                RA_THR:  d.thr    = reg_wdata;
                RA_STAT: w1c      = reg_wdata[STAT_W-1:0] & CLR_MASK;
                RA_IEN:  d.ien    = reg_wdata[STAT_W-1:0];
                RA_CNT:  d.nbytes = reg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
        d.stat = q.stat & ~w1c;

        if (start_det) begin
            if (q.active) d.stat[B_REP] = 1'b1;
            d.phase = PH_ADDR;
            d.bits  = '0;
            d.drive = 1'b0;
        end else if (stop_det) begin
            if (q.active) d.stat[B_TCOMP] = 1'b1;
            d.phase  = PH_IDLE;
            d.active = 1'b0;
            d.drive  = 1'b0;
        end else begin
            case (q.phase)
                PH_ADDR, PH_RX: begin
                    if (scl_rise && q.bits != BITS_FULL) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                        d.bits  = q.bits + 1'b1;
                    end else if (scl_fall && q.bits == BITS_FULL) begin
                        if (q.phase == PH_ADDR) begin
                            if (q.shreg[BYTE_W-1:1] == OWN_ADDR) begin
                                d.phase       = PH_AACK;
                                d.drive       = 1'b1;
                                d.active      = 1'b1;
                                d.stat[B_TRA] = q.shreg[0];
                            end else begin
                                d.phase  = PH_WAIT;
                                d.active = 1'b0;
                            end
                        end else begin
                            d.phase       = PH_RACK;
                            d.drive       = 1'b1;
                            d.rxd         = q.shreg;
                            d.stat[B_BTF] = 1'b1;
                            if (q.nbytes != '0) d.nbytes = q.nbytes - 1'b1;
                        end
                    end
                end
                PH_AACK, PH_TACK: begin
                    if (q.phase == PH_TACK && scl_rise) begin
                        if (sda_s) begin
                            d.stat[B_NAK] = 1'b1;
                            d.phase       = PH_WAIT;
                        end else begin
                            d.bits = BITS_FULL;
                            if (q.nbytes != '0) d.nbytes = q.nbytes - 1'b1;
                        end
                    end else if (scl_fall && (q.phase == PH_AACK || q.bits == BITS_FULL)) begin
                        d.bits = '0;
                        if (q.stat[B_TRA]) begin
                            d.phase         = PH_TX;
                            d.shreg         = q.thr;
                            d.drive         = !q.thr[BYTE_W-1];
                            d.stat[B_TXRDY] = 1'b1;
                        end else begin
                            d.phase = PH_RX;
                            d.drive = 1'b0;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (q.bits != BITS_LAST) begin
                            d.bits  = q.bits + 1'b1;
                            d.shreg = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.drive = !q.shreg[BYTE_W-2];
                        end else begin
                            d.drive = 1'b0;
                            d.phase = PH_TACK;
                        end
                    end
                end
                PH_RACK: begin
                    if (scl_fall) begin
                        d.drive = 1'b0;
                        d.bits  = '0;
                        d.phase = PH_RX;
                    end
                end
                default: ;
            endcase
        end

        if (reg_wr && reg_addr == RA_THR) d.stat[B_TXRDY] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q              <= '0;
            q.phase        <= PH_IDLE;
            q.stat[B_TXRDY] <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_THR:  reg_rdata = q.thr;
            RA_RXD:  reg_rdata = q.rxd;
            RA_STAT: reg_rdata = 8'(q.stat);
            RA_IEN:  reg_rdata = 8'(q.ien);
            RA_CNT:  reg_rdata = 8'(q.nbytes);
            default: reg_rdata = '0;
        endcase
    end

    assign sda_oe = q.drive;
    assign scl_oe = 1'b0;
    assign irq    = |(q.stat & q.ien);

    // R6
    sda_moves_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);
    // R10
    tcomp_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.stat[B_TCOMP]) |-> $past(stop_det));
    // R9
    rep_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.stat[B_REP]) |-> $past(start_det));
    // R5
    count_never_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == RA_CNT) |=> (q.nbytes <= $past(q.nbytes)));
    // R7
    thr_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_THR) |=> !q.stat[B_TXRDY]);
endmodule

// File: tb/i2c_flag_slave_test.sv
module i2c_flag_slave_test;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_line, sda_line;
    logic scl_oe, sda_oe, reg_wr, irq;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    int errors = 0, checks = 0;
    logic prev_oe = 1'b0;
    int edge_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);

    i2c_flag_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // R6: the slave's data output may only move while the clock line is low
    always @(negedge clk) begin
        if (rst_n && sda_oe != prev_oe && scl_line) edge_bad++;
        prev_oe <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        reg_read(a, v);
        check(tag, v, exp);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; tick(Q);
        m_scl_low = 1'b0; tick(Q);
        m_sda_low = 1'b1; tick(Q);
        m_scl_low = 1'b1; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; tick(Q);
        m_scl_low = 1'b0; tick(Q);
        m_sda_low = 1'b0; tick(Q);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        m_sda_low = !b; tick(Q);
        m_scl_low = 1'b0; tick(Q);
        seen = sda_line; tick(Q);
        m_scl_low = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(!give_ack, s);
    endtask

    task automatic test_reset();
        expect_reg("R1 status", 3'd2, 8'h10);
        expect_reg("R1 irq_en", 3'd3, 8'h00);
        expect_reg("R1 count", 3'd4, 8'h00);
        check("R1 irq/oe", {5'b0, irq, sda_oe, scl_oe}, 8'h00);
    endtask

    task automatic test_receive();
        logic a;
        reg_write(3'd4, 8'd3);
        bus_start();
        send_byte(8'h54, a);
        check("R2 addr ack", {7'b0, a}, 8'h01);
        expect_reg("R2 direction", 3'd2, 8'h10);
        send_byte(8'hC3, a);
        check("R4 data ack", {7'b0, a}, 8'h01);
        expect_reg("R4 rx data", 3'd1, 8'hC3);
        expect_reg("R4 byte done", 3'd2, 8'h12);
        expect_reg("R5 count 2", 3'd4, 8'd2);
        reg_write(3'd2, 8'h02);
        expect_reg("R11 w1c clears", 3'd2, 8'h10);
        send_byte(8'h3C, a);
        expect_reg("R4 rx data 2", 3'd1, 8'h3C);
        expect_reg("R5 count 1", 3'd4, 8'd1);
        reg_write(3'd2, 8'h00);
        expect_reg("R11 zero keeps", 3'd2, 8'h12);
        bus_stop();
        expect_reg("R10 tcomp", 3'd2, 8'h32);
        reg_write(3'd2, 8'h3F);
        expect_reg("R11 ro bits kept", 3'd2, 8'h10);
    endtask

    task automatic test_saturate();
        logic a;
        reg_write(3'd4, 8'd1);
        bus_start();
        send_byte(8'h54, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        bus_stop();
        expect_reg("R5 holds zero", 3'd4, 8'd0);
        expect_reg("R4 last byte", 3'd1, 8'h22);
        reg_write(3'd2, 8'h3F);
    endtask

    task automatic test_foreign();
        logic a;
        bus_start();
        send_byte(8'h56, a);
        check("R3 no addr ack", {7'b0, a}, 8'h00);
        send_byte(8'hFF, a);
        check("R3 no data ack", {7'b0, a}, 8'h00);
        bus_stop();
        expect_reg("R3 status same", 3'd2, 8'h10);
        expect_reg("R3 rx same", 3'd1, 8'h22);
    endtask

    task automatic test_transmit();
        logic a;
        logic [7:0] v;
        reg_write(3'd4, 8'd5);
        reg_write(3'd0, 8'hA6);
        expect_reg("R7 busy after write", 3'd2, 8'h00);
        bus_start();
        send_byte(8'h55, a);
        check("R6 read addr ack", {7'b0, a}, 8'h01);
        expect_reg("R7 ready after load", 3'd2, 8'h11);
        reg_write(3'd0, 8'h5B);
        recv_byte(1'b1, v);
        check("R6 first byte", v, 8'hA6);
        expect_reg("R5 count tx", 3'd4, 8'd4);
        recv_byte(1'b0, v);
        check("R6 second byte", v, 8'h5B);
        expect_reg("R8 nak flag", 3'd2, 8'h15);
        expect_reg("R5 no dec on nak", 3'd4, 8'd4);
        recv_byte(1'b0, v);
        check("R8 released", v, 8'hFF);
        bus_stop();
        expect_reg("R10 tcomp tx", 3'd2, 8'h35);
        reg_write(3'd2, 8'h3F);
    endtask

    task automatic test_repeat();
        logic a;
        bus_start();
        send_byte(8'h54, a);
        send_byte(8'h77, a);
        bus_start();
        send_byte(8'h54, a);
        check("R9 addr after rep", {7'b0, a}, 8'h01);
        send_byte(8'h88, a);
        bus_stop();
        expect_reg("R9 rep flag", 3'd2, 8'h3A);
        expect_reg("R9 rx after rep", 3'd1, 8'h88);
    endtask

    task automatic test_irq();
        tick(2);
        check("R12 mask off", {7'b0, irq}, 8'h00);
        reg_write(3'd3, 8'h20);
        tick(1);
        check("R12 tcomp irq", {7'b0, irq}, 8'h01);
        reg_write(3'd2, 8'h20);
        tick(1);
        check("R12 cleared", {7'b0, irq}, 8'h00);
        reg_write(3'd3, 8'h10);
        tick(1);
        check("R12 txrdy irq", {7'b0, irq}, 8'h01);
        reg_write(3'd3, 8'h00);
        tick(1);
        check("R12 off again", {7'b0, irq}, 8'h00);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        test_reset();
        test_receive();
        test_saturate();
        test_foreign();
        test_transmit();
        test_repeat();
        test_irq();
        check("R6 sda edges", 8'(edge_bad), 8'd0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule